// File: doc/BRIEF.md
# DRAM Interface Mode-Switch Sequencer

This block runs on the controller side and decides which of two signalling modes a dual-mode DRAM uses. One is a narrow-swing serial lane mode that needs the memory's DLL running and suits heavy traffic. The other is a parallel mode with the DLL off that costs less at light load. The block watches a bandwidth-demand figure, in MB/s, that the system measures. When demand stays high for long enough, it asks the memory to start its DLL. While the DLL warms up, parallel traffic keeps flowing. The block then writes the memory's mode register to flip the link to serial, and traffic is blocked for a short, fixed window while the flip happens. When demand falls, the block flips the link back to parallel and only then turns the DLL off. It never passes through power-down to do this. A power-down request is honoured from either mode, and on release the mode that was active before is restored.

Every command goes out on a request/acknowledge handshake toward the memory command path. The status outputs give the current mode, whether traffic may flow, and whether the DLL has been commanded on.

The states are:
- `ST_PAR`: parallel idle.
- `ST_DLL_UP`: DLL-enable command.
- `ST_WARM`: warm-up wait.
- `ST_ABORT`: DLL-disable after a cancelled switch.
- `ST_SER_FLIP`: serial mode write plus blackout.
- `ST_SER`: serial idle.
- `ST_PAR_FLIP`: parallel mode write.
- `ST_DLL_DN`: DLL-disable after return.
- `ST_PD_IN`: power-down entry command.
- `ST_PD`: asleep.
- `ST_PD_OUT`: power-down exit command.

The transitions are:
- `ST_PAR` goes to `ST_PD_IN` on a power-down request, or to `ST_DLL_UP` on qualified high demand.
- `ST_DLL_UP` goes to `ST_WARM` on acknowledge.
- `ST_WARM` goes to `ST_ABORT` on qualified low demand, or to `ST_SER_FLIP` on DLL ready or timeout.
- `ST_ABORT` goes to `ST_PAR` on acknowledge.
- `ST_SER_FLIP` goes to `ST_SER` when the blackout ends.
- `ST_SER` goes to `ST_PD_IN` on a power-down request, or to `ST_PAR_FLIP` on qualified low demand.
- `ST_PAR_FLIP` goes to `ST_DLL_DN` on acknowledge.
- `ST_DLL_DN` goes to `ST_PAR` on acknowledge.
- `ST_PD_IN` goes to `ST_PD` on acknowledge.
- `ST_PD` goes to `ST_PD_OUT` when the request is released.
- `ST_PD_OUT` goes to the saved mode on acknowledge.

Top module: `dram_mode_seq`

## Requirements
- R1: After reset the block reports the parallel mode (`mode` = 0), `traffic_ok` = 1, `dll_en` = 0 and `cmd_req` = 0.
- R2: A switch toward serial starts only when `bw_demand` has been above `HI_THR` for `PERSIST` consecutive cycles. `cmd_req` rises one cycle after the `PERSIST`-th such cycle. A demand between `LO_THR` and `HI_THR` changes nothing in either mode.
- R3: The switch begins with a DLL-enable command (code 1). Throughout warm-up the mode stays parallel (0), `traffic_ok` stays 1 and `dll_en` reads 1.
- R4: Warm-up ends on the first cycle with `dll_ready` high, or after `WARM_CYC` cycles in warm-up, whichever comes first.
- R5: The serial flip sends the serial mode-register write (code 3). It shows `mode` = 3 with `traffic_ok` = 0 for exactly `BLACKOUT` cycles, then `mode` = 1 with `traffic_ok` = 1.
- R6: If `bw_demand` stays below `LO_THR` for `PERSIST` cycles during warm-up, the block sends a DLL-disable command (code 2) and returns to parallel mode with `dll_en` = 0, without ever entering the flip.
- R7: From serial mode, qualified low demand sends the parallel mode-register write (code 4) and then DLL-disable (code 2), with no power-down command in between. The DLL stays commanded on until the code-4 write is acknowledged.
- R8: `pd_req` high in either idle mode sends power-down entry (code 5) and reports `mode` = 2 with `traffic_ok` = 0. Dropping `pd_req` sends power-down exit (code 6) and restores the earlier mode and DLL state.
- R9: `cmd_req` and `cmd_code` hold steady until `cmd_ack` is seen with `cmd_req` high, and the same request is not repeated after its acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_demand | input | DMD_W | Measured bandwidth demand, MB/s |
| dll_ready | input | 1 | DLL lock indication from the memory |
| pd_req | input | 1 | Level request to hold the memory in power-down |
| cmd_ack | input | 1 | Command path accepted the current request |
| cmd_req | output | 1 | Command request toward the memory command path |
| cmd_code | output | 3 | Command: 1 DLL on, 2 DLL off, 3 to serial, 4 to parallel, 5 power-down entry, 6 power-down exit |
| mode | output | 2 | 0 parallel, 1 serial, 2 power-down, 3 switching |
| traffic_ok | output | 1 | Data traffic may be issued |
| dll_en | output | 1 | DLL has been commanded on |

## Verification
The properties assume that the command path acknowledges the serial mode-register write within the blackout window. The bench responder does so on the first falling edge after each request. They also assume that `cmd_ack` is raised only while a request is pending. The responder meets this by answering a request once and dropping the acknowledge on the next cycle. It stalls only on purpose, and only outside the flip. Demand, `dll_ready` and `pd_req` are driven on falling edges. Power-down is requested only from the two idle modes, which the requirements cover.

// File: rtl/msw_pkg.sv
package msw_pkg;

    typedef enum logic [3:0] {
        ST_PAR,
        ST_DLL_UP,
        ST_WARM,
        ST_ABORT,
        ST_SER_FLIP,
        ST_SER,
        ST_PAR_FLIP,
        ST_DLL_DN,
        ST_PD_IN,
        ST_PD,
        ST_PD_OUT
    } msw_state_e;

    typedef enum logic [2:0] {
        CMD_NONE        = 3'd0,
        CMD_DLL_ON      = 3'd1,
        CMD_DLL_OFF     = 3'd2,
        CMD_GO_SERIAL   = 3'd3,
        CMD_GO_PARALLEL = 3'd4,
        CMD_PD_ENTER    = 3'd5,
        CMD_PD_EXIT     = 3'd6
    } msw_cmd_e;

    localparam logic [1:0] MODE_PAR = 2'd0;
    localparam logic [1:0] MODE_SER = 2'd1;
    localparam logic [1:0] MODE_PD  = 2'd2;
    localparam logic [1:0] MODE_SW  = 2'd3;

endpackage

// File: rtl/msw_demand_qual.sv
module msw_demand_qual #(
    parameter int unsigned DMD_W   = 16,
    parameter int unsigned HI_THR  = 1800,
    parameter int unsigned LO_THR  = 1400,
    parameter int unsigned PERSIST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DMD_W-1:0] demand,
    output logic             hi_q,
    output logic             lo_q
);
    localparam int unsigned PW = $clog2(PERSIST + 1);
    localparam logic [PW-1:0] PMAX = PW'(PERSIST);

    logic [PW-1:0] hi_cnt;
    logic [PW-1:0] lo_cnt;
    logic          above;
    logic          below;

    always_comb begin
        above = demand > DMD_W'(HI_THR);
        below = demand < DMD_W'(LO_THR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            if (!above)
                hi_cnt <= '0;
            else if (hi_cnt != PMAX)
                hi_cnt <= hi_cnt + 1'b1;
            if (!below)
                lo_cnt <= '0;
            else if (lo_cnt != PMAX)
                lo_cnt <= lo_cnt + 1'b1;
        end
    end

    always_comb begin
        hi_q = (hi_cnt == PMAX);
        lo_q = (lo_cnt == PMAX);
    end

    // R2: qualified high requires the preceding sample to be above threshold
    a_r2_hi_needs_demand: assert property (@(posedge clk) disable iff (!rst_n)
        hi_q |-> $past(demand) > DMD_W'(HI_THR));

    // R2: qualified high and low can never coexist
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q));

endmodule

// File: rtl/msw_cycle_timer.sv
module msw_cycle_timer #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic zero
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= W'(LIMIT - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    always_comb zero = (cnt == '0);

endmodule

// File: rtl/dram_mode_seq.sv
module dram_mode_seq
    import msw_pkg::*;
#(
    parameter int unsigned DMD_W    = 16,
    parameter int unsigned HI_THR   = 1800,
    parameter int unsigned LO_THR   = 1400,
    parameter int unsigned PERSIST  = 8,
    parameter int unsigned WARM_CYC = 4000,
    parameter int unsigned BLACKOUT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DMD_W-1:0] bw_demand,
    input  logic             dll_ready,
    input  logic             pd_req,
    input  logic             cmd_ack,
    output logic             cmd_req,
    output logic [2:0]       cmd_code,
    output logic [1:0]       mode,
    output logic             traffic_ok,
    output logic             dll_en
);
    localparam int unsigned FLW = $clog2(BLACKOUT + 1) + 1;

    msw_state_e state, nxt;
    msw_cmd_e   cmd_sel;
    logic       hi_q, lo_q;
    logic       warm_zero, flip_zero;
    logic       warm_start, flip_start;
    logic       dll_on_q;
    logic       flip_acked;
    logic       saved_ser;
    logic       ack_now;

    msw_demand_qual #(
        .DMD_W  (DMD_W),
        .HI_THR (HI_THR),
        .LO_THR (LO_THR),
        .PERSIST(PERSIST)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .demand(bw_demand),
        .hi_q  (hi_q),
        .lo_q  (lo_q)
    );

    msw_cycle_timer #(.LIMIT(WARM_CYC)) u_warm_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(warm_start),
        .zero (warm_zero)
    );

    msw_cycle_timer #(.LIMIT(BLACKOUT)) u_flip_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(flip_start),
        .zero (flip_zero)
    );

    always_comb ack_now = cmd_req && cmd_ack;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PAR: begin
                if (pd_req)    nxt = ST_PD_IN;
                else if (hi_q) nxt = ST_DLL_UP;
            end
            ST_DLL_UP:   if (ack_now) nxt = ST_WARM;
            ST_WARM: begin
                if (lo_q)                        nxt = ST_ABORT;
                else if (dll_ready || warm_zero) nxt = ST_SER_FLIP;
            end
            ST_ABORT:    if (ack_now) nxt = ST_PAR;
            ST_SER_FLIP: if (flip_zero) nxt = ST_SER;
            ST_SER: begin
                if (pd_req)    nxt = ST_PD_IN;
                else if (lo_q) nxt = ST_PAR_FLIP;
            end
            ST_PAR_FLIP: if (ack_now) nxt = ST_DLL_DN;
            ST_DLL_DN:   if (ack_now) nxt = ST_PAR;
            ST_PD_IN:    if (ack_now) nxt = ST_PD;
            ST_PD:       if (!pd_req) nxt = ST_PD_OUT;
            ST_PD_OUT:   if (ack_now) nxt = saved_ser ? ST_SER : ST_PAR;
            default:     nxt = ST_PAR;
        endcase
    end

    always_comb begin
        warm_start = (nxt == ST_WARM) && (state != ST_WARM);
        flip_start = (nxt == ST_SER_FLIP) && (state != ST_SER_FLIP);
    end

    // state and bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PAR;
            dll_on_q   <= 1'b0;
            flip_acked <= 1'b0;
            saved_ser  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_DLL_UP && ack_now)
                dll_on_q <= 1'b1;
            else if ((state == ST_ABORT || state == ST_DLL_DN) && ack_now)
                dll_on_q <= 1'b0;
            if (flip_start)
                flip_acked <= 1'b0;
            else if (state == ST_SER_FLIP && ack_now)
                flip_acked <= 1'b1;
            if (nxt == ST_PD_IN && state != ST_PD_IN)
                saved_ser <= (state == ST_SER);
        end
    end

    // outputs decoded from state
    always_comb begin
        cmd_sel    = CMD_NONE;
        cmd_req    = 1'b0;
        mode       = MODE_PAR;
        traffic_ok = 1'b1;
        unique case (state)
            ST_PAR: ;
            ST_DLL_UP: begin
                cmd_sel = CMD_DLL_ON;
                cmd_req = 1'b1;
            end
            ST_WARM: ;
            ST_ABORT: begin
                cmd_sel = CMD_DLL_OFF;
                cmd_req = 1'b1;
            end
            ST_SER_FLIP: begin
                cmd_sel    = CMD_GO_SERIAL;
                cmd_req    = !flip_acked;
                mode       = MODE_SW;
                traffic_ok = 1'b0;
            end
            ST_SER: mode = MODE_SER;
            ST_PAR_FLIP: begin
                cmd_sel    = CMD_GO_PARALLEL;
                cmd_req    = 1'b1;
                mode       = MODE_SW;
                traffic_ok = 1'b0;
            end
            ST_DLL_DN: begin
                cmd_sel = CMD_DLL_OFF;
                cmd_req = 1'b1;
            end
            ST_PD_IN: begin
                cmd_sel    = CMD_PD_ENTER;
                cmd_req    = 1'b1;
                mode       = MODE_PD;
                traffic_ok = 1'b0;
            end
            ST_PD: begin
                mode       = MODE_PD;
                traffic_ok = 1'b0;
            end
            ST_PD_OUT: begin
                cmd_sel    = CMD_PD_EXIT;
                cmd_req    = 1'b1;
                mode       = MODE_PD;
                traffic_ok = 1'b0;
            end
            default: ;
        endcase
        cmd_code = cmd_sel;
        dll_en   = dll_on_q;
    end

    // observation counter for the blackout window
    logic [FLW-1:0] flip_len;
    always_ff @(posedge clk) begin
        if (!rst_n)
            flip_len <= '0;
        else if (state == ST_SER_FLIP)
            flip_len <= flip_len + 1'b1;
        else
            flip_len <= '0;
    end

    // R5: the flip window never outlasts the blackout length
    a_r5_flip_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER_FLIP) |-> (flip_len < FLW'(BLACKOUT)));

    // R5: the serial mode write is accepted inside the window
    a_r5_acked_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER_FLIP && flip_len == FLW'(BLACKOUT - 1)) |-> (flip_acked || cmd_ack));

    // R3: the link only flips to serial with the DLL commanded on
    a_r3_dll_before_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SER_FLIP) |-> dll_en);

    // R7: the DLL stays on while returning to parallel
    a_r7_dll_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAR_FLIP) |-> dll_en);

    // R8: wake-up restores the mode saved at entry
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PD_OUT && cmd_ack) |=> ((state == ST_SER) == saved_ser));

    // R9: a pending request holds its code
    a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_code)));

    // R9: an acknowledged request is not repeated
    a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_ack) |=> !(cmd_req && cmd_code == $past(cmd_code)));

endmodule

// File: tb/dram_mode_seq_bench.sv
module dram_mode_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DMD_W    = 16;
    localparam int PERSIST  = 4;
    localparam int WARM_CYC = 40;
    localparam int BLACKOUT = 10;

    localparam int NV = 8;
    localparam int    V_DMD  [NV] = '{1000, 1600, 2500, 1600, 500, 2500, 2500, 500};
    localparam int    V_RDY  [NV] = '{0, 0, 1, 1, 0, 0, 0, 0};
    localparam int    V_CYC  [NV] = '{20, 20, 30, 20, 20, 30, 30, 20};
    localparam int    V_MODE [NV] = '{0, 0, 1, 1, 0, 0, 1, 0};
    localparam int    V_DLL  [NV] = '{0, 0, 1, 1, 0, 1, 1, 0};
    localparam string V_TAG  [NV] = '{"R2", "R2", "R5", "R2", "R7", "R3", "R4", "R7"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DMD_W-1:0] bw_demand = '0;
    logic             dll_ready = 1'b0;
    logic             pd_req = 1'b0;
    logic             cmd_ack = 1'b0;
    logic             cmd_req;
    logic [2:0]       cmd_code;
    logic [1:0]       mode;
    logic             traffic_ok;
    logic             dll_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit ack_hold = 1'b0;
    int n_log = 0;
    int log_code [64];
    int log_dll  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_mode_seq #(
        .DMD_W(DMD_W), .HI_THR(1800), .LO_THR(1400), .PERSIST(PERSIST),
        .WARM_CYC(WARM_CYC), .BLACKOUT(BLACKOUT)
    ) u_dram_mode_seq (
        .clk(clk), .rst_n(rst_n), .bw_demand(bw_demand), .dll_ready(dll_ready),
        .pd_req(pd_req), .cmd_ack(cmd_ack), .cmd_req(cmd_req), .cmd_code(cmd_code),
        .mode(mode), .traffic_ok(traffic_ok), .dll_en(dll_en)
    );

    // command path model: answer each request once, log what was accepted
    always @(negedge clk) begin
        if (!rst_n || ack_hold) begin
            cmd_ack = 1'b0;
        end else if (cmd_req && !cmd_ack) begin
            cmd_ack = 1'b1;
            if (n_log < 64) begin
                log_code[n_log] = int'(cmd_code);
                log_dll[n_log]  = int'(dll_en);
            end
            n_log++;
        end else begin
            cmd_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int last_code();
        return (n_log > 0 && n_log <= 64) ? log_code[n_log-1] : -1;
    endfunction

    initial begin
        int idx;
        int sw;
        int bad;
        bit saw_sw;

        // R1: reset state
        bw_demand = 16'd1000;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk(mode == 2'd0, "R1 mode", int'(mode), 0);
        chk(traffic_ok == 1'b1, "R1 traffic", int'(traffic_ok), 1);
        chk(dll_en == 1'b0, "R1 dll", int'(dll_en), 0);
        chk(cmd_req == 1'b0, "R1 req", int'(cmd_req), 0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            bw_demand = DMD_W'(V_DMD[i]);
            dll_ready = V_RDY[i][0];
            tick(V_CYC[i]);
            chk(int'(mode) == V_MODE[i], {V_TAG[i], " vec mode"}, int'(mode), V_MODE[i]);
            chk(traffic_ok == 1'b1, {V_TAG[i], " vec traffic"}, int'(traffic_ok), 1);
            chk(int'(dll_en) == V_DLL[i], {V_TAG[i], " vec dll"}, int'(dll_en), V_DLL[i]);
        end

        // R2 exact persistence, R3 first command, R5 blackout length
        dll_ready = 1'b0;
        bw_demand = 16'd2500;
        tick(PERSIST);
        chk(cmd_req == 1'b0, "R2 early req", int'(cmd_req), 0);
        tick(1);
        chk(cmd_req == 1'b1, "R2 req after persist", int'(cmd_req), 1);
        chk(cmd_code == 3'd1, "R3 dll-on code", int'(cmd_code), 1);
        dll_ready = 1'b1;
        sw = 0;
        bad = 0;
        for (int k = 0; k < 60; k++) begin
            tick(1);
            if (mode == 2'd3) begin
                sw++;
                if (traffic_ok) bad++;
            end
            if (mode == 2'd1 && sw > 0) break;
        end
        chk(sw == BLACKOUT, "R5 blackout cycles", sw, BLACKOUT);
        chk(bad == 0, "R5 traffic in blackout", bad, 0);
        chk(mode == 2'd1 && traffic_ok, "R5 serial after flip", int'(mode), 1);
        chk(last_code() == 3, "R5 serial write", last_code(), 3);

        // R8 power-down from serial
        pd_req = 1'b1;
        tick(5);
        chk(mode == 2'd2, "R8 pd mode", int'(mode), 2);
        chk(traffic_ok == 1'b0, "R8 pd traffic", int'(traffic_ok), 0);
        chk(last_code() == 5, "R8 pd enter", last_code(), 5);
        pd_req = 1'b0;
        tick(5);
        chk(mode == 2'd1, "R8 restore serial", int'(mode), 1);
        chk(dll_en == 1'b1, "R8 dll kept", int'(dll_en), 1);
        chk(last_code() == 6, "R8 pd exit", last_code(), 6);

        // R7 direct return to parallel
        idx = n_log;
        bw_demand = 16'd500;
        dll_ready = 1'b0;
        tick(20);
        chk(mode == 2'd0, "R7 parallel", int'(mode), 0);
        chk(dll_en == 1'b0, "R7 dll off", int'(dll_en), 0);
        chk(n_log == idx + 2, "R7 command count", n_log - idx, 2);
        chk(log_code[idx] == 4, "R7 first cmd", log_code[idx], 4);
        chk(log_dll[idx] == 1, "R7 dll on at write", log_dll[idx], 1);
        chk(log_code[idx+1] == 2, "R7 second cmd", log_code[idx+1], 2);

        // R8 power-down from parallel
        pd_req = 1'b1;
        tick(5);
        chk(mode == 2'd2, "R8 pd from parallel", int'(mode), 2);
        pd_req = 1'b0;
        tick(5);
        chk(mode == 2'd0, "R8 restore parallel", int'(mode), 0);
        chk(dll_en == 1'b0, "R8 dll still off", int'(dll_en), 0);

        // R6 abort during warm-up
        idx = n_log;
        bw_demand = 16'd2500;
        tick(10);
        chk(dll_en == 1'b1 && mode == 2'd0, "R6 in warm-up", int'(dll_en), 1);
        bw_demand = 16'd500;
        saw_sw = 1'b0;
        for (int k = 0; k < 20; k++) begin
            tick(1);
            if (mode == 2'd3) saw_sw = 1'b1;
        end
        chk(!saw_sw, "R6 no flip", int'(saw_sw), 0);
        chk(mode == 2'd0 && dll_en == 1'b0, "R6 back parallel", int'(dll_en), 0);
        chk(n_log == idx + 2 && log_code[idx] == 1 && log_code[idx+1] == 2,
            "R6 commands", log_code[idx+1], 2);

        // R9 stalled handshake holds request
        ack_hold = 1'b1;
        bw_demand = 16'd2500;
        tick(PERSIST + 2);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (!cmd_req || cmd_code != 3'd1 || dll_en) bad++;
        end
        chk(bad == 0, "R9 request held", bad, 0);
        ack_hold = 1'b0;
        tick(3);
        chk(dll_en == 1'b1 && cmd_req == 1'b0, "R9 accepted once", int'(cmd_req), 0);

        // R1 reset in the middle of warm-up
        rst_n = 1'b0;
        tick(2);
        chk(mode == 2'd0 && traffic_ok && !dll_en && !cmd_req, "R1 mid-run reset",
            int'(dll_en), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule